// File: doc/BRIEF.md
# Automatic Transmit/Receive GPIO Controller

This block drives two 16-bit general-purpose I/O banks that face a half-duplex radio front end: one bank sits on the transmit side and one on the receive side. Each pin can be driven directly by software, or it can follow the transceiver's transmit/receive status without any software action. A per-bit automatic-control mask makes that choice. Pins under automatic control take their level from a transmit-time value or from a receive-time value, picked by a registered copy of a status input that is high while the transmit path has data pending.

Software writes each bank through a single write port. The direct-value and output-enable registers accept masked writes: the upper half of the 32-bit write word chooses which bits change, and the lower half carries the new values. The automatic-control mask, the transmit-time value and the receive-time value are replaced whole. A pin with its output enable cleared is an input, so its pad is left in high impedance. A 32-bit readback word returns the level seen on every pin of both banks, with the receive-side bank in the upper half.

The transmit/receive status passes through a two-state machine. Its states are `MODE_RX` (receive, entered at reset) and `MODE_TX` (transmit). The transition `MODE_RX -> MODE_TX` happens on the clock edge that samples `tx_active` high. The transition `MODE_TX -> MODE_RX` happens on the edge that samples it low. In every other case the machine holds its state.

Top module: `gpio_atr_ctrl`

## Requirements
- R1: After reset every register of both banks is 0: all output enables are 0, all driven values are 0, and the readback equals the external pin levels.
- R2: A write to address 0 (direct value) changes only those bits whose matching bit in `wr_data[31:16]` is 1; each such bit takes the value of the matching bit of `wr_data[15:0]`.
- R3: A write to address 1 (output enable) follows the same masked rule as R2, and `*_pin_oe` shows the register from the edge after the write onward.
- R4: Writes to address 2 (automatic mask), 3 (transmit-time value) and 4 (receive-time value) replace the whole register with `wr_data[15:0]`.
- R5: For a pin whose automatic-mask bit is 1, the driven value is the transmit-time bit while the mode is transmit and the receive-time bit while the mode is receive.
- R6: For a pin whose automatic-mask bit is 0, the driven value is the direct-value bit, whatever the mode.
- R7: The mode starts in receive after reset. It becomes transmit on the first clock edge that samples `tx_active` at 1, and receive on the first edge that samples it at 0. The pin values change only at that edge.
- R8: A pin whose output-enable bit is 0 has its `*_pin_oe` bit at 0 (pad high impedance), whatever value is selected for it.
- R9: `rd_data[31:16]` holds the receive-side bank (`wr_bank`=1) and `rd_data[15:0]` holds the transmit-side bank (`wr_bank`=0). Each bit is the driven value when its output enable is 1 and the external pin level when its output enable is 0.
- R10: A write reaches only the bank named by `wr_bank`. Writes to addresses 5 to 7 change nothing, and without `wr_en` no register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_active | input | 1 | High while the transmit path has data pending |
| wr_en | input | 1 | Register write strobe |
| wr_bank | input | 1 | Bank selected for the write: 0 transmit side, 1 receive side |
| wr_addr | input | 3 | Register address: 0 direct, 1 enable, 2 auto mask, 3 tx value, 4 rx value |
| wr_data | input | 32 | Write word: mask in 31:16 for masked registers, value in 15:0 |
| txs_pin_i | input | 16 | External levels of the transmit-side pins |
| txs_pin_o | output | 16 | Values driven onto the transmit-side pins |
| txs_pin_oe | output | 16 | Output enables of the transmit-side pins |
| rxs_pin_i | input | 16 | External levels of the receive-side pins |
| rxs_pin_o | output | 16 | Values driven onto the receive-side pins |
| rxs_pin_oe | output | 16 | Output enables of the receive-side pins |
| rd_data | output | 32 | Pin-level readback of both banks |

## Verification
The embedded assertions check several rules on every cycle: the mode register follows the sampled `tx_active` with exactly one edge of delay, masked writes leave unselected bits alone, whole-word writes land intact, and registers hold still when no write is made. Other behaviours can only be shown by the bench's scenarios against its own arithmetic model. These are the per-bit choice between automatic and direct values, the separation between the two banks, the ignored addresses, and the readback of undriven pins such as a lock-detect input on bit 15. The bench covers them with a long pseudo-random sweep of writes, status changes and pin levels, plus directed cases for the mode-switch edge.

// File: rtl/gpio_atr_pkg.sv
package gpio_atr_pkg;

    // Register addresses within one bank
    typedef enum logic [2:0] {
        REG_DIRECT = 3'd0,   // masked write
        REG_OE     = 3'd1,   // masked write
        REG_AUTO   = 3'd2,   // plain write
        REG_TXVAL  = 3'd3,   // plain write
        REG_RXVAL  = 3'd4    // plain write
    } reg_addr_e;

    // Transmit/receive mode of the front end
    typedef enum logic {
        MODE_RX = 1'b0,
        MODE_TX = 1'b1
    } tr_mode_e;

    localparam int NUM_BANKS = 2;   // 0: transmit side, 1: receive side

endpackage

// File: rtl/gpio_atr_mode_fsm.sv
module gpio_atr_mode_fsm
    import gpio_atr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_active,
    output logic transmit
);

    tr_mode_e mode_q;
    tr_mode_e mode_d;

    // Next-state logic
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_RX: if (tx_active)  mode_d = MODE_TX;
            MODE_TX: if (!tx_active) mode_d = MODE_RX;
            default: mode_d = MODE_RX;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_RX;
        else        mode_q <= mode_d;
    end

    // Output decode
    always_comb begin
        unique case (mode_q)
            MODE_TX: transmit = 1'b1;
            default: transmit = 1'b0;
        endcase
    end

    // R7
    enter_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_active |=> (mode_q == MODE_TX));

    // R7
    enter_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_active |=> (mode_q == MODE_RX));

endmodule

// File: rtl/gpio_atr_bank.sv
module gpio_atr_bank
    import gpio_atr_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [2:0]           wr_addr,
    input  logic [2*WIDTH-1:0]   wr_data,
    input  logic                 transmit,
    input  logic [WIDTH-1:0]     pin_i,
    output logic [WIDTH-1:0]     pin_o,
    output logic [WIDTH-1:0]     pin_oe,
    output logic [WIDTH-1:0]     level
);

    localparam int WORD_W = 2 * WIDTH;

    logic [WIDTH-1:0] dir_q, oe_q, auto_q, txv_q, rxv_q;
    logic [WIDTH-1:0] wmask, wval;

    assign wmask = wr_data[WORD_W-1:WIDTH];
    assign wval  = wr_data[WIDTH-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '0;
            oe_q   <= '0;
            auto_q <= '0;
            txv_q  <= '0;
            rxv_q  <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                REG_DIRECT: dir_q  <= (dir_q & ~wmask) | (wval & wmask);
                REG_OE:     oe_q   <= (oe_q  & ~wmask) | (wval & wmask);
                REG_AUTO:   auto_q <= wval;
                REG_TXVAL:  txv_q  <= wval;
                REG_RXVAL:  rxv_q  <= wval;
                default:    ;
            endcase
        end
    end

    // Per-bit source selection and pad level
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic atr_bit;
        assign atr_bit  = transmit ? txv_q[i] : rxv_q[i];
        assign pin_o[i] = auto_q[i] ? atr_bit : dir_q[i];
        assign pin_oe[i] = oe_q[i];
        assign level[i] = oe_q[i] ? pin_o[i] : pin_i[i];
    end

    // R2
    dir_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == REG_DIRECT)
        |=> ((dir_q ^ $past(dir_q)) & ~$past(wr_data[WORD_W-1:WIDTH])) == '0);

    // R3
    oe_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == REG_OE)
        |=> ((oe_q ^ $past(oe_q)) & ~$past(wr_data[WORD_W-1:WIDTH])) == '0);

    // R4
    auto_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == REG_AUTO) |=> (auto_q == $past(wr_data[WIDTH-1:0])));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(dir_q) && $stable(oe_q) && $stable(auto_q)
                    && $stable(txv_q) && $stable(rxv_q)));

endmodule

// File: rtl/gpio_atr_pack.sv
module gpio_atr_pack
    import gpio_atr_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0]           level [NUM_BANKS],
    output logic [NUM_BANKS*WIDTH-1:0] rd_data
);

    // Bank 0 (transmit side) fills the low half, bank 1 the high half
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_slot
        assign rd_data[b*WIDTH +: WIDTH] = level[b];
    end

endmodule

// File: rtl/gpio_atr_ctrl.sv
module gpio_atr_ctrl
    import gpio_atr_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tx_active,
    input  logic                 wr_en,
    input  logic                 wr_bank,
    input  logic [2:0]           wr_addr,
    input  logic [2*WIDTH-1:0]   wr_data,
    input  logic [WIDTH-1:0]     txs_pin_i,
    output logic [WIDTH-1:0]     txs_pin_o,
    output logic [WIDTH-1:0]     txs_pin_oe,
    input  logic [WIDTH-1:0]     rxs_pin_i,
    output logic [WIDTH-1:0]     rxs_pin_o,
    output logic [WIDTH-1:0]     rxs_pin_oe,
    output logic [2*WIDTH-1:0]   rd_data
);

    logic             transmit;
    logic [WIDTH-1:0] pin_i_a  [NUM_BANKS];
    logic [WIDTH-1:0] pin_o_a  [NUM_BANKS];
    logic [WIDTH-1:0] pin_oe_a [NUM_BANKS];
    logic [WIDTH-1:0] level_a  [NUM_BANKS];

    gpio_atr_mode_fsm u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_active (tx_active),
        .transmit  (transmit)
    );

    assign pin_i_a[0]  = txs_pin_i;
    assign pin_i_a[1]  = rxs_pin_i;
    assign txs_pin_o   = pin_o_a[0];
    assign txs_pin_oe  = pin_oe_a[0];
    assign rxs_pin_o   = pin_o_a[1];
    assign rxs_pin_oe  = pin_oe_a[1];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic bank_wr;
        assign bank_wr = wr_en && (wr_bank == b[0]);

        gpio_atr_bank #(.WIDTH(WIDTH)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (bank_wr),
            .wr_addr  (wr_addr),
            .wr_data  (wr_data),
            .transmit (transmit),
            .pin_i    (pin_i_a[b]),
            .pin_o    (pin_o_a[b]),
            .pin_oe   (pin_oe_a[b]),
            .level    (level_a[b])
        );
    end

    gpio_atr_pack #(.WIDTH(WIDTH)) u_pack (
        .level   (level_a),
        .rd_data (rd_data)
    );

endmodule

// File: tb/gpio_atr_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_atr_ctrl_bench;

    localparam int W = 16;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          tx_active = 1'b0;
    logic          wr_en = 1'b0;
    logic          wr_bank = 1'b0;
    logic [2:0]    wr_addr = '0;
    logic [2*W-1:0] wr_data = '0;
    logic [W-1:0]  txs_pin_i = '0, rxs_pin_i = '0;
    logic [W-1:0]  txs_pin_o, txs_pin_oe, rxs_pin_o, rxs_pin_oe;
    logic [2*W-1:0] rd_data;

    gpio_atr_ctrl u_gpio_atr_ctrl (
        .clk(clk), .rst_n(rst_n), .tx_active(tx_active),
        .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr), .wr_data(wr_data),
        .txs_pin_i(txs_pin_i), .txs_pin_o(txs_pin_o), .txs_pin_oe(txs_pin_oe),
        .rxs_pin_i(rxs_pin_i), .rxs_pin_o(rxs_pin_o), .rxs_pin_oe(rxs_pin_oe),
        .rd_data(rd_data)
    );

    int n_tests = 0;
    int n_fail  = 0;

    // Bench model of the registers
    logic [W-1:0] m_dir [2], m_oe [2], m_auto [2], m_tx [2], m_rx [2];
    logic         m_mode = 1'b0;
    logic [31:0]  seed = 32'h1BADF00D;

    function automatic logic [31:0] next_rand(logic [31:0] s);
        logic [31:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    function automatic logic [W-1:0] exp_out(int b);
        return (m_auto[b] & (m_mode ? m_tx[b] : m_rx[b])) | (~m_auto[b] & m_dir[b]);
    endfunction

    function automatic logic [W-1:0] exp_lvl(int b, logic [W-1:0] pin);
        return (m_oe[b] & exp_out(b)) | (~m_oe[b] & pin);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_all(string ctx);
        chk({ctx, " R5/R6 txs_pin_o"}, {16'h0, txs_pin_o}, {16'h0, exp_out(0)});
        chk({ctx, " R5/R6 rxs_pin_o"}, {16'h0, rxs_pin_o}, {16'h0, exp_out(1)});
        chk({ctx, " R3/R8 txs_pin_oe"}, {16'h0, txs_pin_oe}, {16'h0, m_oe[0]});
        chk({ctx, " R3/R8 rxs_pin_oe"}, {16'h0, rxs_pin_oe}, {16'h0, m_oe[1]});
        chk({ctx, " R9 rd_data"}, rd_data,
            {exp_lvl(1, rxs_pin_i), exp_lvl(0, txs_pin_i)});
    endtask

    task automatic tick();
        @(posedge clk);
        if (rst_n && wr_en) begin
            case (wr_addr)
                3'd0: m_dir[wr_bank] = (m_dir[wr_bank] & ~wr_data[31:16]) | (wr_data[15:0] & wr_data[31:16]);
                3'd1: m_oe[wr_bank]  = (m_oe[wr_bank]  & ~wr_data[31:16]) | (wr_data[15:0] & wr_data[31:16]);
                3'd2: m_auto[wr_bank] = wr_data[15:0];
                3'd3: m_tx[wr_bank]   = wr_data[15:0];
                3'd4: m_rx[wr_bank]   = wr_data[15:0];
                default: ;
            endcase
        end
        if (rst_n) m_mode = tx_active;
        #1;
        wr_en = 1'b0;
    endtask

    task automatic wr(logic b, logic [2:0] a, logic [31:0] d);
        wr_en = 1'b1; wr_bank = b; wr_addr = a; wr_data = d;
        tick();
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int b = 0; b < 2; b++) begin
            m_dir[b] = '0; m_oe[b] = '0; m_auto[b] = '0; m_tx[b] = '0; m_rx[b] = '0;
        end
        txs_pin_i = 16'hC3A1;
        rxs_pin_i = 16'h8E17;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();

        // R1: reset state
        chk("R1 txs_pin_oe", {16'h0, txs_pin_oe}, 32'h0);
        chk("R1 rxs_pin_oe", {16'h0, rxs_pin_oe}, 32'h0);
        chk("R1 pin_o", {rxs_pin_o, txs_pin_o}, 32'h0);
        chk("R1 readback", rd_data, {16'h8E17, 16'hC3A1});

        // R2: masked direct write, low byte only
        wr(1'b1, 3'd1, 32'hFFFF_FFFF);
        wr(1'b1, 3'd0, 32'h00FF_1234);
        chk("R2 direct masked", {16'h0, rxs_pin_o}, 32'h0000_0034);
        wr(1'b1, 3'd0, 32'hF000_FFFF);
        chk("R2 direct masked 2", {16'h0, rxs_pin_o}, 32'h0000_F034);

        // R3: masked enable write
        wr(1'b0, 3'd1, 32'h0F0F_FFFF);
        chk("R3 enable masked", {16'h0, txs_pin_oe}, 32'h0000_0F0F);

        // R4 / R7: whole-word writes and the mode-switch edge
        wr(1'b0, 3'd1, 32'hFFFF_FFFF);
        wr(1'b0, 3'd2, 32'h0000_FFFF);
        wr(1'b0, 3'd3, 32'h0000_A5A5);
        wr(1'b0, 3'd4, 32'h0000_5A5A);
        chk("R4 rx value", {16'h0, txs_pin_o}, 32'h0000_5A5A);
        tx_active = 1'b1;
        #2;
        chk("R7 no change before edge", {16'h0, txs_pin_o}, 32'h0000_5A5A);
        tick();
        chk("R7 transmit after edge", {16'h0, txs_pin_o}, 32'h0000_A5A5);
        tx_active = 1'b0;
        #2;
        chk("R7 hold before edge", {16'h0, txs_pin_o}, 32'h0000_A5A5);
        tick();
        chk("R7 receive after edge", {16'h0, txs_pin_o}, 32'h0000_5A5A);

        // R8 / R9: undriven lock-detect style bit 15 on the receive side
        wr(1'b1, 3'd1, 32'h8000_0000);
        chk("R8 bit15 high-Z", {31'h0, rxs_pin_oe[15]}, 32'h0);
        rxs_pin_i[15] = 1'b1; #1;
        chk("R9 bit15 follows pin", {31'h0, rd_data[31]}, 32'h1);
        rxs_pin_i[15] = 1'b0; #1;
        chk("R9 bit15 follows pin low", {31'h0, rd_data[31]}, 32'h0);

        // R10: ignored addresses
        wr(1'b0, 3'd5, 32'hFFFF_FFFF);
        wr(1'b1, 3'd7, 32'hFFFF_0000);
        check_all("R10 unused address");

        // Sweep of writes, status and pin levels
        for (int it = 0; it < 1500; it++) begin
            seed = next_rand(seed);
            tx_active = seed[3];
            txs_pin_i = seed[31:16];
            seed = next_rand(seed);
            rxs_pin_i = seed[15:0];
            if (seed[20]) begin
                logic b;
                logic [2:0] a;
                b = seed[21];
                a = seed[24:22];
                seed = next_rand(seed);
                wr(b, a, seed);
            end else begin
                tick();
            end
            check_all("sweep R4 R5 R6 R10");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule